// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a description of where the page behind it lives. It fetches a first-level entry from a table whose base is given on an input port. It then fetches a second-level entry from the table page that the first entry points to. The final entry is classified as a plain resident page, a compressed resident page, or a page held on disk. For a plain page the block returns the full physical byte address. For a compressed page it returns the byte location and byte length. For a disk page it returns the disk page number.

The virtual address is split into three fields, from the top bit down: a first-level index, a second-level index and a page byte offset. By default these are 8, 11 and 13 bits. Every table entry is 4 bytes. Second-level tables, like plain pages, sit in the uncompressed region, whose base is a second input.

Only one walk is in flight at a time. Memory is reached through a read port that holds its request until a response-valid pulse arrives. The response may come in the same cycle as the request. The result is presented with a one-cycle done pulse.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high only when no walk is in progress. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. A request presented while a walk is in progress is ignored and does not change that walk's result.
- R2: In the cycle after a request is taken, `mem_rd_valid_o` is high with `mem_rd_addr_o` = first-level base + 4 × vaddr[31:24]. The request and its address stay unchanged until a cycle in which `mem_rsp_valid_i` is high.
- R3: If bit 31 of the first-level entry is set, the walk ends after that single read. The outcome code is 3 and `disk_page_o` = entry[18:0].
- R4: If bit 31 of the first-level entry is clear, the next read address is uncompressed base + (entry[10:0] << 13) + 4 × vaddr[23:13]. Entry bits 28:11 have no effect on it.
- R5: A second-level entry with bit 31 set gives outcome code 2 and `disk_page_o` = entry[18:0]. Bits 28:19 are ignored.
- R6: A second-level entry with bit 31 clear and a nonzero size field [28:20] gives outcome code 1. It also gives `cmp_addr_o` = entry[19:0] × 16 and `cmp_len_o` = entry[28:20] × 16.
- R7: A second-level entry with bit 31 clear and a zero size field gives outcome code 0. It also gives `phys_addr_o` = uncompressed base + (entry[10:0] << 13) + vaddr[12:0]. Bits 19:11 are ignored.
- R8: `dirty_o` and `spare_o` carry bits 30 and 29 of the entry that ended the walk.
- R9: `done_o` is high for exactly one cycle: the cycle after the response that ends the walk. Result fields that do not belong to the outcome code read zero while `done_o` is high. `req_ready_o` is high again in that same cycle.
- R10: After reset, `req_ready_o` is high, and `done_o` and `mem_rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l1_base_i | input | 32 | Byte address of the first-level table |
| ucomp_base_i | input | 32 | Byte base of the uncompressed region |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| mem_rd_valid_o | output | 1 | Memory read request, held until response |
| mem_rd_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle result strobe |
| kind_o | output | 2 | 0 plain, 1 compressed, 2 leaf on disk, 3 table on disk |
| phys_addr_o | output | 32 | Physical byte address of a plain page |
| cmp_addr_o | output | 24 | Byte location of a compressed page |
| cmp_len_o | output | 13 | Byte length of a compressed page |
| disk_page_o | output | 19 | Disk page number |
| dirty_o | output | 1 | Dirty bit of the final entry |
| spare_o | output | 1 | Spare bit of the final entry |

## Verification
The bench builds the walker with its default index and offset widths, 8, 11 and 13 bits. With these widths both table indices can be driven to their extremes. The top and bottom of the page offset fall into the plain address sum. The compressed size field reaches both its smallest nonzero value and its all-ones value.

Response latency is varied from zero to three cycles. This exposes both the same-cycle response path and the hold of a pending read. The table base and the region base are randomized, so carries through the address adders are exercised.

// File: rtl/pt_walk_pkg.sv
// Shared entry layout constants and result types for the page table walker.
// Assumes 32-bit table entries and a 16-byte granule for compressed pages.
package pt_walk_pkg;

    localparam int ENT_W     = 32;
    localparam int ADDR_W    = 32;
    localparam int DISK_BIT  = 31;
    localparam int DIRTY_BIT = 30;
    localparam int SPARE_BIT = 29;
    localparam int SIZE_HI   = 28;
    localparam int SIZE_LO   = 20;
    localparam int SIZE_W    = SIZE_HI - SIZE_LO + 1;
    localparam int LOC_W     = 20;
    localparam int PPN_W     = 11;
    localparam int DPN_W     = 19;
    localparam int GRAN_SH   = 4;
    localparam int CADDR_W   = LOC_W + GRAN_SH;
    localparam int CLEN_W    = SIZE_W + GRAN_SH;

    typedef enum logic [1:0] {
        KIND_PLAIN      = 2'd0,
        KIND_PACKED     = 2'd1,
        KIND_LEAF_DISK  = 2'd2,
        KIND_TABLE_DISK = 2'd3
    } walk_kind_e;

    typedef struct packed {
        walk_kind_e           kind;
        logic [ADDR_W-1:0]    phys;
        logic [CADDR_W-1:0]   caddr;
        logic [CLEN_W-1:0]    clen;
        logic [DPN_W-1:0]     dpn;
        logic                 dirty;
        logic                 spare;
    } walk_res_t;

endpackage

// File: rtl/pt_addr_gen.sv
// Forms the byte addresses of the first- and second-level entries.
// Assumes the second-level table occupies one page of the uncompressed region.
module pt_addr_gen
    import pt_walk_pkg::*;
#(
    parameter int L1_IDX_W = 8,
    parameter int L2_IDX_W = 11,
    parameter int OFF_W    = 13
) (
    input  logic [ADDR_W-1:0]                    l1_base,
    input  logic [ADDR_W-1:0]                    ucomp_base,
    input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0]   vaddr,
    input  logic [PPN_W-1:0]                     tbl_ppn,
    output logic [ADDR_W-1:0]                    l1_addr,
    output logic [ADDR_W-1:0]                    l2_addr
);
    localparam int VA_W   = L1_IDX_W + L2_IDX_W + OFF_W;
    localparam int L2_LO  = OFF_W;
    localparam int L1_LO  = OFF_W + L2_IDX_W;

    logic [L1_IDX_W-1:0] idx1;
    logic [L2_IDX_W-1:0] idx2;

    assign idx1 = vaddr[VA_W-1:L1_LO];
    assign idx2 = vaddr[L1_LO-1:L2_LO];

    // Entry addresses: base plus index scaled by the 4-byte entry size.
    always_comb begin
        l1_addr = l1_base + (ADDR_W'(idx1) << 2);
        l2_addr = ucomp_base + (ADDR_W'(tbl_ppn) << OFF_W) + (ADDR_W'(idx2) << 2);
    end

endmodule

// File: rtl/pt_leaf_decode.sv
// Classifies the entry that ends a walk and extracts its fields.
// Fields not belonging to the chosen kind are driven to zero.
module pt_leaf_decode
    import pt_walk_pkg::*;
#(
    parameter int OFF_W = 13
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic              from_l1,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] ucomp_base,
    output walk_res_t         res
);
    logic [SIZE_W-1:0] size_f;

    assign size_f = entry[SIZE_HI:SIZE_LO];

    // Kind selection and per-kind field extraction.
    always_comb begin
        res       = '0;
        res.dirty = entry[DIRTY_BIT];
        res.spare = entry[SPARE_BIT];
        if (from_l1) begin
            res.kind = KIND_TABLE_DISK;
            res.dpn  = entry[DPN_W-1:0];
        end else if (entry[DISK_BIT]) begin
            res.kind = KIND_LEAF_DISK;
            res.dpn  = entry[DPN_W-1:0];
        end else if (size_f != '0) begin
            res.kind  = KIND_PACKED;
            res.caddr = {entry[LOC_W-1:0], {GRAN_SH{1'b0}}};
            res.clen  = {size_f, {GRAN_SH{1'b0}}};
        end else begin
            res.kind = KIND_PLAIN;
            res.phys = ucomp_base + (ADDR_W'(entry[PPN_W-1:0]) << OFF_W)
                     + ADDR_W'(offset);
        end
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Sequencer for one walk: idle, first-level read, second-level read.
// Assumes a held read request and a response that may arrive in the same cycle.
module pt_walk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_valid,
    input  logic rsp_disk,
    output logic ready,
    output logic rd_valid,
    output logic sel_l2,
    output logic in_l1,
    output logic take_req,
    output logic take_tbl,
    output logic finish
);
    typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2} st_e;
    st_e st_q, st_d;

    // Next state and step strobes.
    always_comb begin
        st_d     = st_q;
        take_req = 1'b0;
        take_tbl = 1'b0;
        finish   = 1'b0;
        case (st_q)
            S_IDLE: if (req_valid) begin
                take_req = 1'b1;
                st_d     = S_RD1;
            end
            S_RD1: if (rsp_valid) begin
                if (rsp_disk) begin
                    finish = 1'b1;
                    st_d   = S_IDLE;
                end else begin
                    take_tbl = 1'b1;
                    st_d     = S_RD2;
                end
            end
            S_RD2: if (rsp_valid) begin
                finish = 1'b1;
                st_d   = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    assign ready    = (st_q == S_IDLE);
    assign rd_valid = (st_q != S_IDLE);
    assign sel_l2   = (st_q == S_RD2);
    assign in_l1    = (st_q == S_RD1);

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top: captures the request, issues the two
// entry reads and registers the classified result with a one-cycle strobe.
// Assumes a single outstanding walk and word-aligned table bases.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int L1_IDX_W = 8,
    parameter int L2_IDX_W = 11,
    parameter int OFF_W    = 13,
    localparam int VA_W    = L1_IDX_W + L2_IDX_W + OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   l1_base_i,
    input  logic [ADDR_W-1:0]   ucomp_base_i,
    input  logic                req_valid_i,
    input  logic [VA_W-1:0]     req_vaddr_i,
    output logic                req_ready_o,
    output logic                mem_rd_valid_o,
    output logic [ADDR_W-1:0]   mem_rd_addr_o,
    input  logic                mem_rsp_valid_i,
    input  logic [ENT_W-1:0]    mem_rsp_data_i,
    output logic                done_o,
    output logic [1:0]          kind_o,
    output logic [ADDR_W-1:0]   phys_addr_o,
    output logic [CADDR_W-1:0]  cmp_addr_o,
    output logic [CLEN_W-1:0]   cmp_len_o,
    output logic [DPN_W-1:0]    disk_page_o,
    output logic                dirty_o,
    output logic                spare_o
);
    logic              sel_l2, in_l1, take_req, take_tbl, finish;
    logic [VA_W-1:0]   va_q;
    logic [PPN_W-1:0]  tbl_ppn_q;
    logic [ADDR_W-1:0] l1_addr, l2_addr;
    walk_res_t         res_d, res_q;
    logic              done_q;

    pt_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid_i),
        .rsp_valid (mem_rsp_valid_i),
        .rsp_disk  (mem_rsp_data_i[DISK_BIT]),
        .ready     (req_ready_o),
        .rd_valid  (mem_rd_valid_o),
        .sel_l2    (sel_l2),
        .in_l1     (in_l1),
        .take_req  (take_req),
        .take_tbl  (take_tbl),
        .finish    (finish)
    );

    pt_addr_gen #(
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W),
        .OFF_W    (OFF_W)
    ) u_addr (
        .l1_base    (l1_base_i),
        .ucomp_base (ucomp_base_i),
        .vaddr      (va_q),
        .tbl_ppn    (tbl_ppn_q),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr)
    );

    pt_leaf_decode #(
        .OFF_W (OFF_W)
    ) u_dec (
        .entry      (mem_rsp_data_i),
        .from_l1    (in_l1),
        .offset     (va_q[OFF_W-1:0]),
        .ucomp_base (ucomp_base_i),
        .res        (res_d)
    );

    // Capture the virtual address and the second-level table page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            tbl_ppn_q <= '0;
        end else begin
            if (take_req) va_q      <= req_vaddr_i;
            if (take_tbl) tbl_ppn_q <= mem_rsp_data_i[PPN_W-1:0];
        end
    end

    // Register the decoded result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) res_q <= res_d;
        end
    end

    assign mem_rd_addr_o = sel_l2 ? l2_addr : l1_addr;
    assign done_o        = done_q;
    assign kind_o        = res_q.kind;
    assign phys_addr_o   = res_q.phys;
    assign cmp_addr_o    = res_q.caddr;
    assign cmp_len_o     = res_q.clen;
    assign disk_page_o   = res_q.dpn;
    assign dirty_o       = res_q.dirty;
    assign spare_o       = res_q.spare;

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checks for the page table walker, attached by bind.
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic        mem_rd_valid_o,
    input logic [31:0] mem_rd_addr_o,
    input logic        mem_rsp_valid_i,
    input logic        done_o,
    input logic [1:0]  kind_o,
    input logic [31:0] phys_addr_o,
    input logic [12:0] cmp_len_o,
    input logic [18:0] disk_page_o
);
    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready_o && mem_rd_valid_o));

    // R2
    accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (mem_rd_valid_o && !req_ready_o));

    // R2
    hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid_o && !mem_rsp_valid_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_rsp_valid_i) && req_ready_o));

    // R6
    packed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == 2'd1) |-> (cmp_len_o != 13'd0 && phys_addr_o == 32'd0
                                        && disk_page_o == 19'd0));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .mem_rd_valid_o  (mem_rd_valid_o),
    .mem_rd_addr_o   (mem_rd_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .done_o          (done_o),
    .kind_o          (kind_o),
    .phys_addr_o     (phys_addr_o),
    .cmp_len_o       (cmp_len_o),
    .disk_page_o     (disk_page_o)
);

// File: tb/tb_pt_walker.sv
// Self-checking bench: directed corner walks plus seeded random walks,
// with a bench-side memory responder of variable latency.
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] l1_base, u_base;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_ready, rd_valid, rsp_valid, done;
    logic [31:0] rd_addr, rsp_data, phys;
    logic [1:0]  kind;
    logic [23:0] caddr;
    logic [12:0] clen;
    logic [18:0] dpn;
    logic        dirty, spare;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .l1_base_i(l1_base), .ucomp_base_i(u_base),
        .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_ready_o(req_ready),
        .mem_rd_valid_o(rd_valid), .mem_rd_addr_o(rd_addr),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
        .done_o(done), .kind_o(kind), .phys_addr_o(phys), .cmp_addr_o(caddr),
        .cmp_len_o(clen), .disk_page_o(dpn), .dirty_o(dirty), .spare_o(spare)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [1:0] exp_kind(logic [31:0] e1, logic [31:0] e2);
        if (e1[31])               return 2'd3;
        if (e2[31])               return 2'd2;
        if (e2[28:20] != 9'd0)    return 2'd1;
        return 2'd0;
    endfunction

    // Full result check against values computed from the requirements.
    task automatic check_result(logic [31:0] va, logic [31:0] e1, logic [31:0] e2);
        logic [1:0]  k;
        logic [31:0] fe, ep;
        logic [23:0] ec;
        logic [12:0] el;
        logic [18:0] ed;
        k  = exp_kind(e1, e2);
        fe = e1[31] ? e1 : e2;
        ep = (k == 2'd0) ? u_base + {8'd0, e2[10:0], 13'd0} + {19'd0, va[12:0]} : 32'd0;
        ec = (k == 2'd1) ? {e2[19:0], 4'd0} : 24'd0;
        el = (k == 2'd1) ? {e2[28:20], 4'd0} : 13'd0;
        ed = (k[1]) ? fe[18:0] : 19'd0;
        chk(kind == k, (k == 3) ? "R3 kind" : (k == 2) ? "R5 kind" : (k == 1) ? "R6 kind" : "R7 kind",
            {30'd0, kind}, {30'd0, k});
        chk(phys == ep, "R7 phys", phys, ep);
        chk(caddr == ec && clen == el, "R6 cmp fields", {caddr, 8'd0} | {19'd0, clen},
            {ec, 8'd0} | {19'd0, el});
        chk(dpn == ed, (k == 3) ? "R3 disk page" : "R5 disk page", {13'd0, dpn}, {13'd0, ed});
        chk(dirty == fe[30] && spare == fe[29], "R8 dirty/spare",
            {30'd0, dirty, spare}, {30'd0, fe[30], fe[29]});
    endtask

    // One walk; starts and ends on a falling edge.
    task automatic walk(logic [31:0] va, logic [31:0] e1, logic [31:0] e2,
                        int lat, bit poke);
        logic [31:0] a1, a2;
        a1 = l1_base + {22'd0, va[31:24], 2'b00};
        a2 = u_base + {8'd0, e1[10:0], 13'd0} + {19'd0, va[23:13], 2'b00};
        chk(req_ready == 1'b1, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rd_valid && rd_addr == a1, "R2 first read", rd_addr, a1);
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = ~va;
            chk(req_ready == 1'b0, "R1 busy", {31'd0, req_ready}, 32'd0);
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(rd_valid && rd_addr == a1, "R2 held read", rd_addr, a1);
        end
        req_valid = 1'b0;
        rsp_valid = 1'b1;
        rsp_data  = e1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_data  = 32'd0;
        if (e1[31]) begin
            chk(done == 1'b1, "R9 done after table fault", {31'd0, done}, 32'd1);
            chk(rd_valid == 1'b0, "R3 single read", {31'd0, rd_valid}, 32'd0);
        end else begin
            chk(done == 1'b0 && rd_valid && rd_addr == a2, "R4 second read", rd_addr, a2);
            for (int i = 0; i < lat; i++) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = e2;
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_data  = 32'd0;
            chk(done == 1'b1, "R9 done after leaf", {31'd0, done}, 32'd1);
        end
        check_result(va, e1, e2);
        chk(req_ready == 1'b1, "R9 ready with done", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] e1, e2;
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = 32'd0;
        rsp_valid = 1'b0;
        rsp_data  = 32'd0;
        l1_base   = 32'h0010_0000;
        u_base    = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(req_ready && !done && !rd_valid, "R10 reset state",
            {29'd0, req_ready, done, rd_valid}, 32'd4);

        // R3 table on disk
        walk(32'hA5C3_1234, 32'hC00A_5A5A, 32'h0, 0, 0);
        // R4 ignored first-level bits, R7 ignored leaf bits 19:11
        walk(32'h0102_4ABC, 32'h1FFF_F803, 32'h200F_F805, 1, 0);
        // R6 smallest size
        walk(32'h7F00_0001, 32'h0000_0010, 32'h0010_0001, 0, 0);
        // R6 largest size and location
        walk(32'h00FF_E000, 32'h0000_0002, 32'h5FFF_FFFF, 3, 1);
        // R5 ignored disk bits
        walk(32'h1234_5678, 32'h0000_07FF, 32'hBFFF_FFFF, 2, 0);
        // R7 max page number and offset, R1 busy request ignored
        walk(32'hFFFF_FFFF, 32'h0000_07FF, 32'h0000_07FF, 2, 1);

        for (int n = 0; n < 400; n++) begin
            l1_base = $urandom() & 32'hFFFF_FFFC;
            u_base  = $urandom();
            e1 = $urandom();
            e1[31] = ($urandom_range(3) == 0);
            e2 = $urandom();
            if ($urandom_range(2) == 0) e2[28:20] = 9'd0;
            if ($urandom_range(2) == 0) e2[31] = 1'b0;
            walk($urandom(), e1, e2, $urandom_range(3), ($urandom_range(3) == 0));
        end
        summary();
        $finish;
    end

endmodule